// File: doc/BRIEF.md
# FIFO-Gated DMA Transfer Scheduler

This block decides when a DMA engine's receive channel, transmit channel and descriptor fetcher may start a bus transfer, and how many beats each transfer asks for. The transmit channel is held back until the transmit FIFO can take a whole burst, or can take everything left in the frame when that is less than a burst. The receive channel is held back until the receive FIFO holds a whole burst, or until an end-of-frame sits in the FIFO. A granted transfer is handed to a burst engine as a start address, a beat count and a source code over a valid/ready command port.

After the command is accepted, the burst engine pulses `beat_i` once per bus beat. In fixed-burst mode a short final receive transfer still asks for a full burst. The block then raises `beat_dummy_o` on the padding beats, so that downstream logic discards them and does not count them as frame bytes. Descriptor fetches are 16 bytes and always use the largest burst that the programmed burst length and the bus width allow.

The controller is a three-state machine. In `ST_IDLE` it checks the sources in priority order (receive, then transmit, then descriptor) and latches the winner. The transition IDLE→ISSUE is taken when any source is eligible. In `ST_ISSUE` it presents the command, and ISSUE→BEAT is taken when `cmd_ready_i` is high. In `ST_BEAT` it counts beats, and BEAT→IDLE is taken on the last beat. Only one command is in flight at a time.

Top module: `dma_burst_sched`

## Requirements
- R1: After reset `cmd_valid_o` and `beat_dummy_o` are 0 and `cmd_src_o` is 0 (none).
- R2: A transmit command starts only when `tx_remain_i` is nonzero and `tx_free_i` is at least the smaller of `tx_remain_i` and the burst size in bytes (burst length × BUS_BYTES).
- R3: A receive command starts only when `rx_level_i` is at least one burst in bytes, or when `rx_eof_i` is 1 and `rx_level_i` is nonzero.
- R4: For transmit, and for receive with fixed bursts off, the beat count is the ceiling of min(bytes, burst bytes) / BUS_BYTES, where bytes is the frame remainder (transmit) or the FIFO level (receive).
- R5: With fixed bursts on, a receive command always asks for the full burst length. The last burst-length minus ceil(level/BUS_BYTES) beats are flagged with `beat_dummy_o`=1 and the earlier beats with 0.
- R6: A descriptor command asks for min(burst length, 16/BUS_BYTES) beats at `desc_addr_i`.
- R7: Priority is receive over transmit over descriptor. The source codes are 1 for receive, 2 for transmit and 3 for descriptor. No new command is presented until every beat of the current one has been counted.
- R8: While `cmd_valid_o` is 1 and `cmd_ready_i` is 0, the address, beat count and source stay unchanged, even when the channel inputs change. The address is the one of the selected source.
- R9: A programmed burst length of 0 is treated as 1.
- R10: Transmit and descriptor commands never carry dummy beats, in either burst mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fixed_burst_i | input | 1 | 1 = fixed-length bursts with receive padding |
| pbl_i | input | PBL_W | Programmed burst length in beats |
| rx_req_i | input | 1 | Receive channel wants to move data |
| rx_addr_i | input | AW | Receive buffer address |
| rx_level_i | input | LEN_W | Bytes held in receive FIFO |
| rx_eof_i | input | 1 | End-of-frame present in receive FIFO |
| tx_req_i | input | 1 | Transmit channel wants to move data |
| tx_addr_i | input | AW | Transmit buffer address |
| tx_free_i | input | LEN_W | Free bytes in transmit FIFO |
| tx_remain_i | input | LEN_W | Bytes left in current transmit frame |
| desc_req_i | input | 1 | Descriptor fetch wanted |
| desc_addr_i | input | AW | Descriptor address |
| cmd_valid_o | output | 1 | Command presented to burst engine |
| cmd_ready_i | input | 1 | Burst engine accepts command |
| cmd_addr_o | output | AW | Start address |
| cmd_beats_o | output | PBL_W | Number of beats |
| cmd_src_o | output | 2 | 0 none, 1 receive, 2 transmit, 3 descriptor |
| beat_i | input | 1 | One bus beat performed |
| beat_dummy_o | output | 1 | Current beat is padding |

## Verification
The start gates are tried with FIFO room or level exactly at the threshold and one byte below it. This separates a `>=` comparison from a `>` comparison and exposes an off-by-one in the burst-size shift. Short frames with a byte count that is not a multiple of the bus width check the ceiling rounding. The same short receive frame is run with fixed bursts on and off, which shows whether padding is added only in fixed mode and lands on the trailing beats. Competing simultaneous requests, a request raised during a running transfer, and channel inputs changed while the command is stalled show the priority, the single-command rule and the command hold.

// File: rtl/dma_sched_pkg.sv
package dma_sched_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_BEAT  = 2'd2
    } sched_st_e;

    localparam logic [1:0] SRC_NONE = 2'd0;
    localparam logic [1:0] SRC_RX   = 2'd1;
    localparam logic [1:0] SRC_TX   = 2'd2;
    localparam logic [1:0] SRC_DESC = 2'd3;

endpackage

// File: rtl/chan_gate.sv
// Start gate for one channel: eligible when avail covers min(need, burst).
module chan_gate #(
    parameter int LEN_W = 16,
    parameter int PBL_W = 6,
    parameter int BB    = 4
) (
    input  logic             req_i,
    input  logic [PBL_W-1:0] pbl_i,
    input  logic [LEN_W-1:0] avail_i,
    input  logic [LEN_W-1:0] need_i,
    output logic             ok_o,
    output logic [PBL_W-1:0] beats_o
);
    localparam int BB_LG = $clog2(BB);
    localparam int SUM_W = LEN_W + 1;

    logic [SUM_W-1:0] burst_bytes;
    logic [SUM_W-1:0] take;
    logic [SUM_W-1:0] ceil_beats;

    always_comb begin
        burst_bytes = SUM_W'(pbl_i) << BB_LG;
        take        = ({1'b0, need_i} < burst_bytes) ? {1'b0, need_i} : burst_bytes;
        ok_o        = req_i && (need_i != '0) && ({1'b0, avail_i} >= take);
        ceil_beats  = (take + SUM_W'(BB - 1)) >> BB_LG;
        beats_o     = PBL_W'(ceil_beats);
    end

endmodule

// File: rtl/beat_track.sv
// Counts beats of the accepted command and flags padding beats.
module beat_track #(
    parameter int PBL_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             active_i,
    input  logic             beat_i,
    input  logic [PBL_W-1:0] total_i,
    input  logic [PBL_W-1:0] data_i,
    output logic             dummy_o,
    output logic             last_o
);
    logic [PBL_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= '0;
        end else if (active_i && beat_i) begin
            cnt_q <= cnt_q + PBL_W'(1);
        end
    end

    always_comb begin
        dummy_o = active_i && (cnt_q >= data_i);
        last_o  = (cnt_q == total_i - PBL_W'(1));
    end

    // R7
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active_i |-> cnt_q < total_i);

endmodule

// File: rtl/dma_burst_sched.sv
module dma_burst_sched
    import dma_sched_pkg::*;
#(
    parameter int AW    = 32,
    parameter int LEN_W = 16,
    parameter int PBL_W = 6,
    parameter int BB    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fixed_burst_i,
    input  logic [PBL_W-1:0] pbl_i,
    input  logic             rx_req_i,
    input  logic [AW-1:0]    rx_addr_i,
    input  logic [LEN_W-1:0] rx_level_i,
    input  logic             rx_eof_i,
    input  logic             tx_req_i,
    input  logic [AW-1:0]    tx_addr_i,
    input  logic [LEN_W-1:0] tx_free_i,
    input  logic [LEN_W-1:0] tx_remain_i,
    input  logic             desc_req_i,
    input  logic [AW-1:0]    desc_addr_i,
    output logic             cmd_valid_o,
    input  logic             cmd_ready_i,
    output logic [AW-1:0]    cmd_addr_o,
    output logic [PBL_W-1:0] cmd_beats_o,
    output logic [1:0]       cmd_src_o,
    input  logic             beat_i,
    output logic             beat_dummy_o
);
    localparam int BB_LG    = $clog2(BB);
    localparam int SUM_W    = LEN_W + 1;
    localparam int DESC_CAP = 16 / BB;

    sched_st_e        state_q, state_d;
    logic [AW-1:0]    addr_q, sel_addr;
    logic [PBL_W-1:0] beats_q, sel_beats;
    logic [PBL_W-1:0] data_q, sel_data;
    logic [1:0]       src_q, sel_src;

    logic [PBL_W-1:0] pbl_eff, desc_beats;
    logic [LEN_W-1:0] rx_need;
    logic             rx_ok, tx_ok;
    logic [PBL_W-1:0] rx_beats, tx_beats;
    logic             trk_last, trk_dummy;

    always_comb begin
        pbl_eff    = (pbl_i == '0) ? PBL_W'(1) : pbl_i;
        desc_beats = (pbl_eff < PBL_W'(DESC_CAP)) ? pbl_eff : PBL_W'(DESC_CAP);
        // without end-of-frame the receive side must wait for a whole burst
        rx_need    = rx_eof_i ? rx_level_i : '1;
    end

    chan_gate #(.LEN_W(LEN_W), .PBL_W(PBL_W), .BB(BB)) u_rx_gate (
        .req_i  (rx_req_i),
        .pbl_i  (pbl_eff),
        .avail_i(rx_level_i),
        .need_i (rx_need),
        .ok_o   (rx_ok),
        .beats_o(rx_beats)
    );

    chan_gate #(.LEN_W(LEN_W), .PBL_W(PBL_W), .BB(BB)) u_tx_gate (
        .req_i  (tx_req_i),
        .pbl_i  (pbl_eff),
        .avail_i(tx_free_i),
        .need_i (tx_remain_i),
        .ok_o   (tx_ok),
        .beats_o(tx_beats)
    );

    // source selection, receive first
    always_comb begin
        sel_src   = SRC_NONE;
        sel_addr  = '0;
        sel_beats = '0;
        sel_data  = '0;
        if (rx_ok) begin
            sel_src   = SRC_RX;
            sel_addr  = rx_addr_i;
            sel_data  = rx_beats;
            sel_beats = fixed_burst_i ? pbl_eff : rx_beats;
        end else if (tx_ok) begin
            sel_src   = SRC_TX;
            sel_addr  = tx_addr_i;
            sel_data  = tx_beats;
            sel_beats = tx_beats;
        end else if (desc_req_i) begin
            sel_src   = SRC_DESC;
            sel_addr  = desc_addr_i;
            sel_data  = desc_beats;
            sel_beats = desc_beats;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (sel_src != SRC_NONE) state_d = ST_ISSUE;
            ST_ISSUE: if (cmd_ready_i)         state_d = ST_BEAT;
            ST_BEAT:  if (beat_i && trk_last)  state_d = ST_IDLE;
            default:                           state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            beats_q <= '0;
            data_q  <= '0;
            src_q   <= SRC_NONE;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE) begin
                addr_q  <= sel_addr;
                beats_q <= sel_beats;
                data_q  <= sel_data;
                src_q   <= sel_src;
            end
        end
    end

    beat_track #(.PBL_W(PBL_W)) u_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (state_q == ST_ISSUE),
        .active_i(state_q == ST_BEAT),
        .beat_i  (beat_i),
        .total_i (beats_q),
        .data_i  (data_q),
        .dummy_o (trk_dummy),
        .last_o  (trk_last)
    );

    always_comb begin
        cmd_valid_o  = (state_q == ST_ISSUE);
        cmd_addr_o   = addr_q;
        cmd_beats_o  = beats_q;
        cmd_src_o    = src_q;
        beat_dummy_o = trk_dummy;
    end

    // R8
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_addr_o)
            && $stable(cmd_beats_o) && $stable(cmd_src_o));

    // R2
    tx_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_valid_o) && cmd_src_o == SRC_TX |->
            (SUM_W'(cmd_beats_o) << BB_LG) < (SUM_W'($past(tx_free_i)) + SUM_W'(BB)));

    // R6
    desc_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o && cmd_src_o == SRC_DESC |-> (SUM_W'(cmd_beats_o) << BB_LG) <= SUM_W'(16));

    // R10
    dummy_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_dummy_o |-> cmd_src_o == SRC_RX);

    // R4
    beats_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> cmd_beats_o != '0);

endmodule

// File: tb/dma_burst_sched_tb.sv
module dma_burst_sched_tb;

    typedef struct packed {
        logic        fx;
        logic [5:0]  pbl;
        logic        rxr;
        logic [15:0] lvl;
        logic        eof;
        logic        txr;
        logic [15:0] fre;
        logic [15:0] rem;
        logic        dr;
        logic        ev;
        logic [1:0]  es;
        logic [5:0]  eb;
        logic [5:0]  ed;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{0, 8, 0,  0, 0, 1, 32, 100, 0, 1, 2, 8, 0},
        '{0, 8, 0,  0, 0, 1, 31, 100, 0, 0, 0, 0, 0},
        '{0, 8, 0,  0, 0, 1, 10,  10, 0, 1, 2, 3, 0},
        '{0, 8, 0,  0, 0, 1,  9,  10, 0, 0, 0, 0, 0},
        '{0, 8, 1, 32, 0, 0,  0,   0, 0, 1, 1, 8, 0},
        '{0, 8, 1, 31, 0, 0,  0,   0, 0, 0, 0, 0, 0},
        '{0, 8, 1, 13, 1, 0,  0,   0, 0, 1, 1, 4, 0},
        '{1, 8, 1, 13, 1, 0,  0,   0, 0, 1, 1, 8, 4},
        '{1, 8, 1, 40, 1, 0,  0,   0, 0, 1, 1, 8, 0},
        '{0, 8, 0,  0, 0, 0,  0,   0, 1, 1, 3, 4, 0},
        '{0, 2, 0,  0, 0, 0,  0,   0, 1, 1, 3, 2, 0},
        '{0, 8, 1, 32, 0, 1, 32, 100, 1, 1, 1, 8, 0},
        '{0, 8, 0,  0, 0, 1, 32, 100, 1, 1, 2, 8, 0},
        '{0, 0, 0,  0, 0, 1,  4, 100, 0, 1, 2, 1, 0},
        '{1, 8, 0,  0, 0, 1, 10,  10, 0, 1, 2, 3, 0},
        '{0, 8, 1,  0, 1, 0,  0,   0, 0, 0, 0, 0, 0},
        '{1, 16, 0, 0, 0, 0,  0,   0, 1, 1, 3, 4, 0},
        '{1, 3, 1,  5, 1, 0,  0,   0, 0, 1, 1, 3, 1}
    };

    function automatic string vec_tag(input int i);
        case (i)
            0, 1, 3:     return "R2";
            2:           return "R4";
            4, 5, 15:    return "R3";
            6:           return "R4";
            7, 8, 17:    return "R5";
            9, 10, 16:   return "R6";
            11, 12:      return "R7";
            13:          return "R9";
            default:     return "R10";
        endcase
    endfunction

    localparam logic [31:0] RX_A = 32'h0000_1000;
    localparam logic [31:0] TX_A = 32'h0000_2000;
    localparam logic [31:0] DS_A = 32'h0000_3000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fixed_burst_i = 1'b0;
    logic [5:0]  pbl_i = 6'd8;
    logic        rx_req_i = 1'b0;
    logic [31:0] rx_addr_i = RX_A;
    logic [15:0] rx_level_i = '0;
    logic        rx_eof_i = 1'b0;
    logic        tx_req_i = 1'b0;
    logic [31:0] tx_addr_i = TX_A;
    logic [15:0] tx_free_i = '0;
    logic [15:0] tx_remain_i = '0;
    logic        desc_req_i = 1'b0;
    logic [31:0] desc_addr_i = DS_A;
    logic        cmd_valid_o;
    logic        cmd_ready_i = 1'b0;
    logic [31:0] cmd_addr_o;
    logic [5:0]  cmd_beats_o;
    logic [1:0]  cmd_src_o;
    logic        beat_i = 1'b0;
    logic        beat_dummy_o;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    dma_burst_sched u_dut (
        .clk(clk), .rst_n(rst_n), .fixed_burst_i(fixed_burst_i), .pbl_i(pbl_i),
        .rx_req_i(rx_req_i), .rx_addr_i(rx_addr_i), .rx_level_i(rx_level_i), .rx_eof_i(rx_eof_i),
        .tx_req_i(tx_req_i), .tx_addr_i(tx_addr_i), .tx_free_i(tx_free_i), .tx_remain_i(tx_remain_i),
        .desc_req_i(desc_req_i), .desc_addr_i(desc_addr_i),
        .cmd_valid_o(cmd_valid_o), .cmd_ready_i(cmd_ready_i), .cmd_addr_o(cmd_addr_o),
        .cmd_beats_o(cmd_beats_o), .cmd_src_o(cmd_src_o),
        .beat_i(beat_i), .beat_dummy_o(beat_dummy_o)
    );

    task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] addr_of(input logic [1:0] s);
        case (s)
            2'd1:    return RX_A;
            2'd2:    return TX_A;
            default: return DS_A;
        endcase
    endfunction

    task automatic clear_reqs();
        rx_req_i = 0; tx_req_i = 0; desc_req_i = 0;
    endtask

    // accept the presented command and run its beats, checking the padding flags
    task automatic run_xfer(input int beats, input int dum, input string tag);
        cmd_ready_i = 1;
        @(negedge clk);
        cmd_ready_i = 0;
        for (int b = 0; b < beats; b++) begin
            beat_i = 1;
            chk(beat_dummy_o == (b >= beats - dum), tag, beat_dummy_o, (b >= beats - dum));
            @(negedge clk);
        end
        beat_i = 0;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(cmd_valid_o == 0, "R1 valid", cmd_valid_o, 0);
        chk(beat_dummy_o == 0, "R1 dummy", beat_dummy_o, 0);
        chk(cmd_src_o == 0, "R1 src", cmd_src_o, 0);
        rst_n = 1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            fixed_burst_i = VECS[i].fx;
            pbl_i       = VECS[i].pbl;
            rx_req_i    = VECS[i].rxr;
            rx_level_i  = VECS[i].lvl;
            rx_eof_i    = VECS[i].eof;
            tx_req_i    = VECS[i].txr;
            tx_free_i   = VECS[i].fre;
            tx_remain_i = VECS[i].rem;
            desc_req_i  = VECS[i].dr;
            @(negedge clk);
            chk(cmd_valid_o == VECS[i].ev, vec_tag(i), cmd_valid_o, VECS[i].ev);
            if (VECS[i].ev) begin
                chk(cmd_src_o == VECS[i].es, vec_tag(i), cmd_src_o, VECS[i].es);
                chk(cmd_beats_o == VECS[i].eb, vec_tag(i), cmd_beats_o, VECS[i].eb);
                chk(cmd_addr_o == addr_of(VECS[i].es), vec_tag(i), cmd_addr_o, addr_of(VECS[i].es));
                clear_reqs();
                run_xfer(int'(VECS[i].eb), int'(VECS[i].ed), vec_tag(i));
                chk(cmd_valid_o == 0, "R7 idle after beats", cmd_valid_o, 0);
            end
            clear_reqs();
            @(negedge clk);
        end

        // R7: a transmit request raised during a receive transfer waits for its end
        fixed_burst_i = 0; pbl_i = 6'd4;
        rx_req_i = 1; rx_level_i = 16; rx_eof_i = 0;
        tx_req_i = 1; tx_free_i = 64; tx_remain_i = 64;
        @(negedge clk);
        chk(cmd_src_o == 2'd1, "R7 rx first", cmd_src_o, 1);
        rx_req_i = 0;
        cmd_ready_i = 1;
        @(negedge clk);
        cmd_ready_i = 0;
        for (int b = 0; b < 4; b++) begin
            chk(cmd_valid_o == 0, "R7 no second cmd", cmd_valid_o, 0);
            beat_i = 1;
            @(negedge clk);
        end
        beat_i = 0;
        chk(cmd_valid_o == 0, "R7 idle gap", cmd_valid_o, 0);
        @(negedge clk);
        chk(cmd_valid_o == 1 && cmd_src_o == 2'd2, "R7 tx follows", cmd_src_o, 2);

        // R8: stalled command holds while channel inputs move
        tx_free_i = 0; tx_remain_i = 3; tx_addr_i = 32'h0000_9999;
        rx_req_i = 1; rx_level_i = 100;
        repeat (3) @(negedge clk);
        chk(cmd_valid_o == 1, "R8 still valid", cmd_valid_o, 1);
        chk(cmd_addr_o == TX_A, "R8 addr held", cmd_addr_o, TX_A);
        chk(cmd_beats_o == 4, "R8 beats held", cmd_beats_o, 4);
        chk(cmd_src_o == 2'd2, "R8 src held", cmd_src_o, 2);
        clear_reqs();
        tx_addr_i = TX_A;
        run_xfer(4, 0, "R10 tx no pad");
        @(negedge clk);
        chk(cmd_valid_o == 0, "R7 final idle", cmd_valid_o, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule